// File: doc/BRIEF.md
# Phased L2 Way Select Controller

This block steers a second-level cache that splits every access into two cycles. In the first cycle the tag arrays of the selected set are read and compared. In the second cycle exactly one data way is read or written. Requests arrive from the first-level data cache. Each request carries a line address, a write flag, a flag saying whether the first-level cache hit, and a way number. The way number records which second-level way already holds the line.

When the first-level cache reports a write hit, the second-level location is already known. The controller keeps every tag way switched off for that access and takes the data way straight from the decoded way number. Read requests and write misses get a full tag lookup: all tag ways are enabled, the hit vector picks the data way, and a lookup with no match raises a miss flag. Every request kind takes the same two cycles, so the bypass saves tag-array activations without changing timing. The tag and data arrays sit outside the block. A running count of tag-way activations is exported so that the savings can be observed.

Top module: `l2_way_select`

## Requirements
- R1: After reset, and again after a reset applied in the middle of an access, `req_ready` is 1, `tag_en`, `data_en` and `lookup_miss` are 0, and `tag_act_count` is 0.
- R2: A request accepted at clock edge k gets its tag phase in the cycle after edge k and its data phase in the cycle after edge k+1. `data_en` is nonzero only in a data phase.
- R3: For a write whose first-level hit flag is 1, `tag_en` stays all zero during the tag phase.
- R4: For a write whose first-level hit flag is 1, the data phase drives `data_en` bit v, where v is `req_way`, and no other bit. `lookup_miss` is 0 whatever the tag arrays hold.
- R5: For a write with hit flag 0, and for every read whatever its hit flag, `tag_en` has all bits set during the tag phase.
- R6: The address is split as tag = `req_addr[ADDR_W-1:INDEX_W+OFFSET_W]`, index = `req_addr[INDEX_W+OFFSET_W-1:OFFSET_W]` and offset = `req_addr[OFFSET_W-1:0]`. `tag_index` shows the index during the tag phase. On a lookup, the data phase enables the single way w whose `tag_rd_valid[w]` is 1 and whose `tag_rd_tag` slice w (bits w*TAG_W up to w*TAG_W+TAG_W-1) equals the address tag.
- R7: A lookup in which no valid way matches gives `lookup_miss` = 1 and `data_en` = 0 in the data phase.
- R8: Write hits, write misses and reads all reach their data phase exactly two edges after acceptance.
- R9: `req_ready` is 0 during a tag phase and 1 when idle or in a data phase. A request presented during a data phase is accepted at once and starts its tag phase in the next cycle.
- R10: `tag_act_count` grows by NUM_WAYS for each lookup and by 0 for each write hit. The new value is visible in the data phase.
- R11: In the data phase, `data_we` equals the request's write flag, and `data_index` and `data_offset` carry the request's index and offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_addr | input | ADDR_W | Line address of the request |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_l1_hit | input | 1 | First-level cache hit flag |
| req_way | input | WAY_W | Recorded second-level way of the line |
| tag_en | output | NUM_WAYS | Tag-array way enables, tag phase |
| tag_index | output | INDEX_W | Set index for the tag arrays |
| tag_rd_tag | input | NUM_WAYS*TAG_W | Stored tags of the indexed set, way w in slice w |
| tag_rd_valid | input | NUM_WAYS | Valid bits of the indexed set |
| data_en | output | NUM_WAYS | Data-array way enable, data phase |
| data_index | output | INDEX_W | Set index for the data arrays |
| data_offset | output | OFFSET_W | Offset within the line |
| data_we | output | 1 | Data-array write strobe |
| lookup_miss | output | 1 | No valid way matched on a lookup |
| tag_act_count | output | CNT_W | Running total of tag-way activations |

## Verification
The main function is driven through four request shapes against a preloaded tag set. A read that matches a different way each time shows that the comparison, not the way number, picks the data way. A read with the hit flag set shows that the flag is ignored for reads. A write hit whose address tag is absent from the arrays, and whose way number disagrees with any match, shows that the bypass really skips comparison. Write misses and reads with no matching tag, including a match only in an invalid way, separate a real hit from a tag-equal stale entry. Back-to-back issue in the data phase and a reset during a tag phase cover the handshake and the recovery path.

// File: rtl/l2ws_pkg.sv
package l2ws_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_TAG  = 2'd1,
        PH_DATA = 2'd2
    } phase_e;

    typedef enum logic [1:0] {
        ACC_WR_HIT  = 2'd0,
        ACC_WR_MISS = 2'd1,
        ACC_RD      = 2'd2
    } acc_e;

    // Reads never skip the lookup: the first-level hit flag only matters for writes.
    function automatic acc_e classify(input logic is_write, input logic l1_hit);
        if (is_write && l1_hit) return ACC_WR_HIT;
        if (is_write)           return ACC_WR_MISS;
        return ACC_RD;
    endfunction

    function automatic logic needs_lookup(input acc_e kind);
        return kind != ACC_WR_HIT;
    endfunction

endpackage

// File: rtl/l2ws_way_decode.sv
module l2ws_way_decode #(
    parameter int NUM_WAYS = 4,
    localparam int WAY_W   = $clog2(NUM_WAYS)
) (
    input  logic [WAY_W-1:0]    way,
    output logic [NUM_WAYS-1:0] onehot
);
    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_dec
        assign onehot[w] = (way == WAY_W'(w));
    end
endmodule

// File: rtl/l2ws_tag_match.sv
module l2ws_tag_match #(
    parameter int NUM_WAYS = 4,
    parameter int TAG_W    = 20
) (
    input  logic                      active,
    input  logic [TAG_W-1:0]          lookup_tag,
    input  logic [NUM_WAYS*TAG_W-1:0] stored_tags,
    input  logic [NUM_WAYS-1:0]       stored_valid,
    output logic [NUM_WAYS-1:0]       hit_vec
);
    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_cmp
        assign hit_vec[w] = active && stored_valid[w] &&
                            (stored_tags[w*TAG_W +: TAG_W] == lookup_tag);
    end
endmodule

// File: rtl/l2ws_act_count.sv
module l2ws_act_count #(
    parameter int NUM_WAYS = 4,
    parameter int CNT_W    = 16,
    localparam int ONES_W  = $clog2(NUM_WAYS + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_WAYS-1:0] way_en,
    output logic [CNT_W-1:0]    count
);
    logic [ONES_W-1:0] ones;

    always_comb begin
        ones = '0;
        for (int w = 0; w < NUM_WAYS; w++) begin
            ones = ones + ONES_W'(way_en[w]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) count <= '0;
        else     count <= count + CNT_W'(ones);
    end
endmodule

// File: rtl/l2_way_select.sv
module l2_way_select
    import l2ws_pkg::*;
#(
    parameter int NUM_WAYS = 4,
    parameter int ADDR_W   = 32,
    parameter int INDEX_W  = 6,
    parameter int OFFSET_W = 6,
    parameter int CNT_W    = 16,
    localparam int WAY_W   = $clog2(NUM_WAYS),
    localparam int TAG_W   = ADDR_W - INDEX_W - OFFSET_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic [ADDR_W-1:0]         req_addr,
    input  logic                      req_write,
    input  logic                      req_l1_hit,
    input  logic [WAY_W-1:0]          req_way,
    output logic [NUM_WAYS-1:0]       tag_en,
    output logic [INDEX_W-1:0]        tag_index,
    input  logic [NUM_WAYS*TAG_W-1:0] tag_rd_tag,
    input  logic [NUM_WAYS-1:0]       tag_rd_valid,
    output logic [NUM_WAYS-1:0]       data_en,
    output logic [INDEX_W-1:0]        data_index,
    output logic [OFFSET_W-1:0]       data_offset,
    output logic                      data_we,
    output logic                      lookup_miss,
    output logic [CNT_W-1:0]          tag_act_count
);
    typedef struct packed {
        acc_e                kind;
        logic [TAG_W-1:0]    tag;
        logic [INDEX_W-1:0]  index;
        logic [OFFSET_W-1:0] offset;
        logic [WAY_W-1:0]    way;
        logic                write;
    } tag_stage_t;

    typedef struct packed {
        logic [NUM_WAYS-1:0] way_en;
        logic                miss;
        logic [INDEX_W-1:0]  index;
        logic [OFFSET_W-1:0] offset;
        logic                write;
    } data_stage_t;

    phase_e      phase_q, phase_d;
    tag_stage_t  p1_q;
    data_stage_t p2_q;
    logic        accept;
    logic        lookup;
    logic [NUM_WAYS-1:0] hit_vec;
    logic [NUM_WAYS-1:0] way_onehot;
    logic [NUM_WAYS-1:0] sel_way;
    logic                sel_miss;

    // Handshake: the tag phase is the only cycle that cannot take a new request.
    assign req_ready = (phase_q != PH_TAG);
    assign accept    = req_valid && req_ready;

    always_comb begin
        if (accept)                phase_d = PH_TAG;
        else if (phase_q == PH_TAG) phase_d = PH_DATA;
        else                       phase_d = PH_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) phase_q <= PH_IDLE;
        else     phase_q <= phase_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            p1_q <= '0;
        end else if (accept) begin
            p1_q.kind   <= classify(req_write, req_l1_hit);
            p1_q.tag    <= req_addr[ADDR_W-1 -: TAG_W];
            p1_q.index  <= req_addr[OFFSET_W +: INDEX_W];
            p1_q.offset <= req_addr[OFFSET_W-1:0];
            p1_q.way    <= req_way;
            p1_q.write  <= req_write;
        end
    end

    // Phase 1: tag enables are all-on for lookups and all-off for write hits.
    assign lookup    = (phase_q == PH_TAG) && needs_lookup(p1_q.kind);
    assign tag_en    = lookup ? '1 : '0;
    assign tag_index = p1_q.index;

    l2ws_tag_match #(
        .NUM_WAYS (NUM_WAYS),
        .TAG_W    (TAG_W)
    ) match_i (
        .active       (lookup),
        .lookup_tag   (p1_q.tag),
        .stored_tags  (tag_rd_tag),
        .stored_valid (tag_rd_valid),
        .hit_vec      (hit_vec)
    );

    l2ws_way_decode #(
        .NUM_WAYS (NUM_WAYS)
    ) dec_i (
        .way    (p1_q.way),
        .onehot (way_onehot)
    );

    // Data-way select sits at the phase boundary, ahead of the phase-2 register.
    assign sel_way  = needs_lookup(p1_q.kind) ? hit_vec : way_onehot;
    assign sel_miss = needs_lookup(p1_q.kind) && (hit_vec == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            p2_q <= '0;
        end else if (phase_q == PH_TAG) begin
            p2_q.way_en <= sel_way;
            p2_q.miss   <= sel_miss;
            p2_q.index  <= p1_q.index;
            p2_q.offset <= p1_q.offset;
            p2_q.write  <= p1_q.write;
        end
    end

    // Phase 2: outputs qualified by the data phase.
    assign data_en     = (phase_q == PH_DATA) ? p2_q.way_en : '0;
    assign lookup_miss = (phase_q == PH_DATA) && p2_q.miss;
    assign data_we     = (phase_q == PH_DATA) && p2_q.write;
    assign data_index  = p2_q.index;
    assign data_offset = p2_q.offset;

    l2ws_act_count #(
        .NUM_WAYS (NUM_WAYS),
        .CNT_W    (CNT_W)
    ) cnt_i (
        .clk    (clk),
        .rst    (rst),
        .way_en (tag_en),
        .count  (tag_act_count)
    );

endmodule

// File: rtl/l2ws_checker.sv
module l2ws_checker #(
    parameter int NUM_WAYS = 4,
    parameter int CNT_W    = 16
) (
    input logic                clk,
    input logic                rst,
    input logic                req_valid,
    input logic                req_ready,
    input logic                req_write,
    input logic                req_l1_hit,
    input logic [NUM_WAYS-1:0] tag_en,
    input logic [NUM_WAYS-1:0] data_en,
    input logic                lookup_miss,
    input logic [CNT_W-1:0]    tag_act_count,
    input logic [NUM_WAYS-1:0] hit_vec
);
    logic acc;
    assign acc = req_valid && req_ready;

    p_wr_hit_tags_off_r3: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(acc && req_write && req_l1_hit)) |-> (tag_en == '0));

    p_lookup_tags_on_r5: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(acc && !(req_write && req_l1_hit))) |-> (tag_en == '1));

    p_data_after_tag_r2: assert property (@(posedge clk) disable iff (rst)
        (data_en != '0) |-> $past(!req_ready));

    p_fixed_latency_r8: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst, 2) && $past(!rst) && $past(acc, 2)) |-> ((data_en != '0) || lookup_miss));

    p_miss_no_way_r7: assert property (@(posedge clk) disable iff (rst)
        lookup_miss |-> (data_en == '0));

    p_data_onehot_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(data_en));

    p_hit_vec_onehot_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec));

    p_busy_in_tag_r9: assert property (@(posedge clk) disable iff (rst)
        (tag_en != '0) |-> !req_ready);

    p_count_step_r10: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && (tag_act_count != $past(tag_act_count))) |->
        ((tag_act_count - $past(tag_act_count)) == CNT_W'(NUM_WAYS)));

endmodule

bind l2_way_select l2ws_checker #(
    .NUM_WAYS (NUM_WAYS),
    .CNT_W    (CNT_W)
) chk_i (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_write     (req_write),
    .req_l1_hit    (req_l1_hit),
    .tag_en        (tag_en),
    .data_en       (data_en),
    .lookup_miss   (lookup_miss),
    .tag_act_count (tag_act_count),
    .hit_vec       (hit_vec)
);

// File: tb/l2_way_select_tb.sv
module l2_way_select_tb_top;
    localparam int NUM_WAYS = 4;
    localparam int ADDR_W   = 32;
    localparam int INDEX_W  = 6;
    localparam int OFFSET_W = 6;
    localparam int CNT_W    = 16;
    localparam int WAY_W    = 2;
    localparam int TAG_W    = ADDR_W - INDEX_W - OFFSET_W;
    localparam int SETS     = 1 << INDEX_W;
    localparam int NVEC     = 9;

    logic                      clk = 1'b0;
    logic                      rst = 1'b1;
    logic                      req_valid = 1'b0;
    logic                      req_ready;
    logic [ADDR_W-1:0]         req_addr = '0;
    logic                      req_write = 1'b0;
    logic                      req_l1_hit = 1'b0;
    logic [WAY_W-1:0]          req_way = '0;
    logic [NUM_WAYS-1:0]       tag_en;
    logic [INDEX_W-1:0]        tag_index;
    logic [NUM_WAYS*TAG_W-1:0] tag_rd_tag;
    logic [NUM_WAYS-1:0]       tag_rd_valid;
    logic [NUM_WAYS-1:0]       data_en;
    logic [INDEX_W-1:0]        data_index;
    logic [OFFSET_W-1:0]       data_offset;
    logic                      data_we;
    logic                      lookup_miss;
    logic [CNT_W-1:0]          tag_act_count;

    logic [TAG_W-1:0] mem_tag [NUM_WAYS][SETS];
    logic             mem_vld [NUM_WAYS][SETS];

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    int exp_cnt = 0;

    always #5 clk = ~clk;

    l2_way_select #(
        .NUM_WAYS (NUM_WAYS),
        .ADDR_W   (ADDR_W),
        .INDEX_W  (INDEX_W),
        .OFFSET_W (OFFSET_W),
        .CNT_W    (CNT_W)
    ) dut_i (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_addr      (req_addr),
        .req_write     (req_write),
        .req_l1_hit    (req_l1_hit),
        .req_way       (req_way),
        .tag_en        (tag_en),
        .tag_index     (tag_index),
        .tag_rd_tag    (tag_rd_tag),
        .tag_rd_valid  (tag_rd_valid),
        .data_en       (data_en),
        .data_index    (data_index),
        .data_offset   (data_offset),
        .data_we       (data_we),
        .lookup_miss   (lookup_miss),
        .tag_act_count (tag_act_count)
    );

    // Behavioural tag store, read combinationally by index.
    always_comb begin
        for (int w = 0; w < NUM_WAYS; w++) begin
            tag_rd_tag[w*TAG_W +: TAG_W] = mem_tag[w][tag_index];
            tag_rd_valid[w]              = mem_vld[w][tag_index];
        end
    end

    // {write, l1_hit, way, tag, index, expected data_en}; miss expected when data_en is 0
    localparam logic [33:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 2'd0, 20'h00333, 6'd5, 4'b0100},
        {1'b0, 1'b1, 2'd1, 20'h00444, 6'd5, 4'b1000},
        {1'b1, 1'b0, 2'd3, 20'h00111, 6'd5, 4'b0001},
        {1'b1, 1'b1, 2'd2, 20'h00999, 6'd5, 4'b0100},
        {1'b1, 1'b1, 2'd0, 20'h00abc, 6'd9, 4'b0001},
        {1'b0, 1'b0, 2'd1, 20'h00abc, 6'd9, 4'b0100},
        {1'b0, 1'b0, 2'd2, 20'h00555, 6'd9, 4'b0000},
        {1'b1, 1'b0, 2'd0, 20'h00777, 6'd5, 4'b0000},
        {1'b1, 1'b1, 2'd3, 20'h00222, 6'd5, 4'b1000}
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic wr, input logic hit, input logic [1:0] way,
                         input logic [TAG_W-1:0] tg, input logic [INDEX_W-1:0] idx,
                         input logic [OFFSET_W-1:0] off);
        req_valid  = 1'b1;
        req_write  = wr;
        req_l1_hit = hit;
        req_way    = way;
        req_addr   = {tg, idx, off};
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        for (int w = 0; w < NUM_WAYS; w++) begin
            for (int s = 0; s < SETS; s++) begin
                mem_tag[w][s] = '0;
                mem_vld[w][s] = 1'b0;
            end
        end
        mem_tag[0][5] = 20'h00111; mem_vld[0][5] = 1'b1;
        mem_tag[1][5] = 20'h00222; mem_vld[1][5] = 1'b1;
        mem_tag[2][5] = 20'h00333; mem_vld[2][5] = 1'b1;
        mem_tag[3][5] = 20'h00444; mem_vld[3][5] = 1'b1;
        mem_tag[1][9] = 20'h00abc; mem_vld[1][9] = 1'b0;
        mem_tag[2][9] = 20'h00abc; mem_vld[2][9] = 1'b1;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check("R1", "req_ready", 32'(req_ready), 32'd1);
        check("R1", "tag_en", 32'(tag_en), 32'd0);
        check("R1", "data_en", 32'(data_en), 32'd0);
        check("R1", "lookup_miss", 32'(lookup_miss), 32'd0);
        check("R1", "tag_act_count", 32'(tag_act_count), 32'd0);

        for (int i = 0; i < NVEC; i++) begin
            logic wr, hit, wrhit;
            logic [1:0] way;
            logic [TAG_W-1:0] tg;
            logic [INDEX_W-1:0] idx;
            logic [3:0] exp_en;
            logic [OFFSET_W-1:0] off;
            {wr, hit, way, tg, idx, exp_en} = VEC[i];
            wrhit = wr && hit;
            off = OFFSET_W'(i * 7 + 3);
            drive(wr, hit, way, tg, idx, off);
            @(negedge clk);
            req_valid = 1'b0;
            // Tag phase
            check("R9", "ready in tag phase", 32'(req_ready), 32'd0);
            check(wrhit ? "R3" : "R5", "tag_en", 32'(tag_en), wrhit ? 32'd0 : 32'hf);
            check("R6", "tag_index", 32'(tag_index), 32'(idx));
            check("R2", "data_en in tag phase", 32'(data_en), 32'd0);
            @(negedge clk);
            // Data phase
            if (!wrhit) exp_cnt += NUM_WAYS;
            check(wrhit ? "R4" : "R6", "data_en", 32'(data_en), 32'(exp_en));
            check(exp_en == 0 ? "R7" : "R4", "lookup_miss", 32'(lookup_miss),
                  32'(exp_en == 4'b0000));
            check("R8", "data phase present", 32'((data_en != 0) || lookup_miss), 32'd1);
            check("R11", "data_we", 32'(data_we), 32'(wr));
            check("R11", "data_index", 32'(data_index), 32'(idx));
            check("R11", "data_offset", 32'(data_offset), 32'(off));
            check("R9", "ready in data phase", 32'(req_ready), 32'd1);
            check("R10", "tag_act_count", 32'(tag_act_count), 32'(exp_cnt));
            @(negedge clk);
            check("R2", "data_en after data phase", 32'(data_en), 32'd0);
        end

        // R9: back-to-back issue from the data phase
        drive(1'b1, 1'b1, 2'd1, 20'h00001, 6'd5, 6'd0);
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        check("R4", "b2b first data_en", 32'(data_en), 32'b0010);
        check("R9", "b2b ready", 32'(req_ready), 32'd1);
        drive(1'b0, 1'b0, 2'd0, 20'h00222, 6'd5, 6'd1);
        @(negedge clk);
        req_valid = 1'b0;
        check("R9", "b2b second tag phase", 32'(tag_en), 32'hf);
        check("R2", "b2b no data in tag phase", 32'(data_en), 32'd0);
        @(negedge clk);
        exp_cnt += NUM_WAYS;
        check("R6", "b2b second data_en", 32'(data_en), 32'b0010);
        check("R10", "b2b count", 32'(tag_act_count), 32'(exp_cnt));
        @(negedge clk);

        // R1: reset during a tag phase
        drive(1'b0, 1'b0, 2'd0, 20'h00333, 6'd5, 6'd2);
        @(negedge clk);
        req_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        check("R1", "mid reset tag_en", 32'(tag_en), 32'd0);
        check("R1", "mid reset count", 32'(tag_act_count), 32'd0);
        check("R1", "mid reset ready", 32'(req_ready), 32'd1);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "mid reset data_en", 32'(data_en), 32'd0);
        check("R1", "mid reset miss", 32'(lookup_miss), 32'd0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule